// File: doc/BRIEF.md
# Transmit Descriptor Walker

This block drives the transmit side of an Ethernet MAC's DMA. It walks a list of descriptors stored in a word-addressed memory. For each descriptor it reads the first four words and checks that software has handed the descriptor over. It then issues up to two buffer transfer commands (an address and a byte length each) to a downstream frame reader. It waits for the MAC to report the frame finished and closes the descriptor by writing it back.

The close writes word 0 with the ownership flag cleared. The software control field is returned exactly as fetched, and the status bits are replaced. When the frame asked for a timestamp and the extended 8-word layout is selected, the captured 64-bit timestamp goes to words 6 and 7 before word 0 is written. Descriptors follow one another either in a ring, at a fixed stride with a wrap flag, or in a chain, through a link held in word 3.

When the engine reaches a descriptor that software still holds, it stops and raises a suspended flag. A poll-demand pulse makes it read that same descriptor again.

Top module: `txd_engine`

## Requirements
- R1: A descriptor is taken only when bit 31 (ownership) of its word 0 is 1. If that bit is 0, the engine issues no command and no write, raises suspended_o, and makes no memory request and no command while suspended.
- R2: After reset the engine is idle, makes no request and keeps suspended_o low. A poll_i pulse starts a fetch at list_base_i. A poll_i pulse while suspended fetches again the descriptor at the address where the engine stopped.
- R3: Word 1 bits [12:0] hold the length of buffer 1 and bits [28:16] the length of buffer 2. Word 2 is the buffer 1 address and word 3 the buffer 2 address. Commands go out buffer 1 first, then buffer 2. A zero length is skipped. cmd_last_o marks the final command of a descriptor.
- R4: When word 0 bit 20 (chain) is set, the next descriptor address is word 3 and no buffer 2 command is issued.
- R5: Without chain, the next address is the current one plus 16 bytes (ext_mode_i = 0) or 32 bytes (ext_mode_i = 1). It is list_base_i instead when word 0 bit 21 (wrap) is set. Chain takes priority over wrap.
- R6: The word 0 write-back carries bit 31 = 0, bits 30:18 as fetched, bit 17 = 0, and bits 16:0 = done_status_i as sampled with done_valid_i.
- R7: With ext_mode_i = 1 and word 0 bit 25 (timestamp request) set, done_ts_i[31:0] is written to word 6 (byte offset 24), then done_ts_i[63:32] to word 7 (offset 28), then word 0. In every other case word 0 is the only write.
- R8: A descriptor that yields no command is closed without waiting for done_valid_i. Its status field is 0 and no timestamp is written.
- R9: A memory request holds mem_addr_o, mem_we_o and mem_wdata_o stable until mem_ready_i. Read data is taken from mem_rdata_i exactly RD_LAT cycles after the accepting edge. Words 0 to 3 are fetched in order at byte offsets 0, 4, 8 and 12.
- R10: A command holds cmd_addr_o and cmd_len_o stable until cmd_ready_i, and cmd_len_o is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 selects the 8-word descriptor layout, 0 the 4-word layout |
| list_base_i | input | AW | Byte address of the first descriptor |
| poll_i | input | 1 | Poll-demand pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | 32 | Read data, RD_LAT cycles after acceptance |
| cmd_valid_o | output | 1 | Transfer command valid |
| cmd_ready_i | input | 1 | Frame reader accepts the command |
| cmd_addr_o | output | 32 | Buffer address |
| cmd_len_o | output | CNT_W | Buffer length in bytes |
| cmd_last_o | output | 1 | Final command of the descriptor |
| done_valid_i | input | 1 | Frame finished pulse |
| done_status_i | input | 17 | Frame status for word 0 bits 16:0 |
| done_ts_i | input | 64 | Captured frame timestamp |
| suspended_o | output | 1 | Stopped on a descriptor owned by software |

## Verification
The bench sweeps every combination of the buffer 1 and buffer 2 zero/non-zero lengths, the timestamp request, chain and wrap, under both descriptor sizes. The memory and command ready lines stall on a fixed pattern throughout. Several kinds of error show up in this sweep. An engine that dropped the zero-length skip would emit zero-length commands. An engine that let chain mode send buffer 2 would push the link address as data. An engine with the stride or wrap priority wrong would fetch the next descriptor from the wrong address. An engine that wrote the timestamp under the compact layout, or after word 0, shows up in the logged write sequence. Separate cases cover a descriptor still owned by software, the quiet suspended state, and a poll-driven resume from the stopped address. The memory model returns garbage outside the exact latency slot, so a capture one cycle early or late corrupts the descriptor.

// File: rtl/txd_pkg.sv
package txd_pkg;

   // Word 0 bit positions that the engine decodes
   localparam int OWN_BIT  = 31;
   localparam int TSE_BIT  = 25;
   localparam int WRAP_BIT = 21;
   localparam int CHN_BIT  = 20;
   localparam int CTRL_LSB = 18;
   localparam int STAT_W   = 17;

   // Word 1 length fields
   localparam int LEN1_LSB  = 0;
   localparam int LEN2_LSB  = 16;
   localparam int LEN_MAX_W = 13;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_EVAL,
      ST_CMD1,
      ST_CMD2,
      ST_DONE_WAIT,
      ST_WR_TSL,
      ST_WR_TSH,
      ST_WR_W0,
      ST_SUSP
   } eng_state_t;

endpackage

// File: rtl/txd_desc_regs.sv
module txd_desc_regs #(
   parameter int NW    = 4,
   parameter int IDX_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_i,
   input  logic [IDX_W-1:0]    idx_i,
   input  logic [31:0]         data_i,
   output logic [NW-1:0][31:0] words_o
);

   if (NW > (1 << IDX_W)) begin : g_bad_idx
      $error("txd_desc_regs: IDX_W too narrow for NW");
   end

   for (genvar i = 0; i < NW; i++) begin : g_word
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (cap_i && idx_i == IDX_W'(i))
            q <= data_i;
      end
      assign words_o[i] = q;
   end

endmodule

// File: rtl/txd_next_addr.sv
module txd_next_addr #(
   parameter int AW        = 32,
   parameter int CMP_BYTES = 16,
   parameter int EXT_BYTES = 32
) (
   input  logic [AW-1:0] cur_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] link_i,
   input  logic          ext_i,
   input  logic          chain_i,
   input  logic          wrap_i,
   output logic [AW-1:0] next_o
);

   always_comb begin
      if (chain_i)
         next_o = link_i;
      else if (wrap_i)
         next_o = base_i;
      else
         next_o = cur_i + (ext_i ? AW'(EXT_BYTES) : AW'(CMP_BYTES));
   end

endmodule

// File: rtl/txd_wb_word.sv
module txd_wb_word #(
   parameter int CTRL_W = 13,
   parameter int STAT_W = 17
) (
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic [31:0]       word_o
);

   localparam int GAP_W = 32 - 1 - CTRL_W - STAT_W;

   if (GAP_W < 1) begin : g_bad_fields
      $error("txd_wb_word: fields overflow the word");
   end

   // ownership released, control returned, reserved gap zero, status merged
   assign word_o = {1'b0, ctrl_i, {GAP_W{1'b0}}, stat_i};

endmodule

// File: rtl/txd_engine.sv
module txd_engine import txd_pkg::*; #(
   parameter int AW     = 32,
   parameter int RD_LAT = 2,
   parameter int CNT_W  = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_mode_i,
   input  logic [AW-1:0]       list_base_i,
   input  logic                poll_i,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [AW-1:0]       mem_addr_o,
   output logic [31:0]         mem_wdata_o,
   input  logic                mem_ready_i,
   input  logic [31:0]         mem_rdata_i,
   output logic                cmd_valid_o,
   input  logic                cmd_ready_i,
   output logic [31:0]         cmd_addr_o,
   output logic [CNT_W-1:0]    cmd_len_o,
   output logic                cmd_last_o,
   input  logic                done_valid_i,
   input  logic [STAT_W-1:0]   done_status_i,
   input  logic [63:0]         done_ts_i,
   output logic                suspended_o
);

   localparam int WORD_B    = 4;
   localparam int RD_WORDS  = 4;
   localparam int IDX_W     = $clog2(RD_WORDS);
   localparam int CMP_BYTES = WORD_B * 4;
   localparam int EXT_BYTES = WORD_B * 8;
   localparam int TSL_OFF   = WORD_B * 6;
   localparam int TSH_OFF   = WORD_B * 7;
   localparam int CTRL_W    = OWN_BIT - CTRL_LSB;
   localparam int LAT_W     = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

   if (RD_LAT < 1) begin : g_bad_lat
      $error("txd_engine: RD_LAT must be at least 1");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("txd_engine: AW must lie in 8..32");
   end
   if (CNT_W < 1 || CNT_W > LEN_MAX_W) begin : g_bad_cnt
      $error("txd_engine: CNT_W must lie in 1..13");
   end

   eng_state_t               st_q;
   logic [AW-1:0]            cur_q;
   logic [IDX_W-1:0]         idx_q;
   logic [STAT_W-1:0]        stat_q;
   logic [63:0]              ts_q;
   logic [RD_WORDS-1:0][31:0] dw;
   logic                     lat_hit;
   logic                     cap;
   logic [CTRL_W-1:0]        ctrl_q;
   logic [CNT_W-1:0]         len1, len2;
   logic                     own, chained, wrap, ts_req, use1, use2;
   logic [31:0]              wb_word;
   logic [AW-1:0]            next_addr;
   logic                     unused_bits;

   // read latency tracking: a constant hit when data returns next cycle
   if (RD_LAT == 1) begin : g_lat_one
      assign lat_hit = 1'b1;
   end else begin : g_lat_cnt
      logic [LAT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (st_q == ST_RD_REQ && mem_ready_i)
            cnt_q <= LAT_W'(RD_LAT - 1);
         else if (st_q == ST_RD_WAIT && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
      assign lat_hit = (cnt_q == '0);
   end

   assign cap = (st_q == ST_RD_WAIT) && lat_hit;

   txd_desc_regs #(.NW(RD_WORDS), .IDX_W(IDX_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap),
      .idx_i   (idx_q),
      .data_i  (mem_rdata_i),
      .words_o (dw)
   );

   assign ctrl_q  = dw[0][OWN_BIT-1:CTRL_LSB];
   assign own     = dw[0][OWN_BIT];
   assign chained = dw[0][CHN_BIT];
   assign wrap    = dw[0][WRAP_BIT];
   assign ts_req  = ext_mode_i && dw[0][TSE_BIT];
   assign len1    = dw[1][LEN1_LSB +: CNT_W];
   assign len2    = dw[1][LEN2_LSB +: CNT_W];
   assign use1    = (len1 != '0);
   assign use2    = !chained && (len2 != '0);
   assign unused_bits = ^{dw[0][CTRL_LSB-1:0], dw[1]};

   txd_wb_word #(.CTRL_W(CTRL_W), .STAT_W(STAT_W)) u_wb (
      .ctrl_i (ctrl_q),
      .stat_i (stat_q),
      .word_o (wb_word)
   );

   txd_next_addr #(.AW(AW), .CMP_BYTES(CMP_BYTES), .EXT_BYTES(EXT_BYTES)) u_next (
      .cur_i   (cur_q),
      .base_i  (list_base_i),
      .link_i  (dw[3][AW-1:0]),
      .ext_i   (ext_mode_i),
      .chain_i (chained),
      .wrap_i  (wrap),
      .next_o  (next_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cur_q  <= '0;
         idx_q  <= '0;
         stat_q <= '0;
         ts_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (poll_i) begin
               cur_q <= list_base_i;
               idx_q <= '0;
               st_q  <= ST_RD_REQ;
            end
            ST_SUSP: if (poll_i) begin
               idx_q <= '0;
               st_q  <= ST_RD_REQ;
            end
            ST_RD_REQ: if (mem_ready_i) st_q <= ST_RD_WAIT;
            ST_RD_WAIT: if (lat_hit) begin
               if (idx_q == IDX_W'(RD_WORDS - 1)) begin
                  st_q <= ST_EVAL;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= ST_RD_REQ;
               end
            end
            ST_EVAL: begin
               if (!own)
                  st_q <= ST_SUSP;
               else if (use1)
                  st_q <= ST_CMD1;
               else if (use2)
                  st_q <= ST_CMD2;
               else begin
                  stat_q <= '0;
                  st_q   <= ST_WR_W0;
               end
            end
            ST_CMD1: if (cmd_ready_i) st_q <= use2 ? ST_CMD2 : ST_DONE_WAIT;
            ST_CMD2: if (cmd_ready_i) st_q <= ST_DONE_WAIT;
            ST_DONE_WAIT: if (done_valid_i) begin
               stat_q <= done_status_i;
               ts_q   <= done_ts_i;
               st_q   <= ts_req ? ST_WR_TSL : ST_WR_W0;
            end
            ST_WR_TSL: if (mem_ready_i) st_q <= ST_WR_TSH;
            ST_WR_TSH: if (mem_ready_i) st_q <= ST_WR_W0;
            ST_WR_W0: if (mem_ready_i) begin
               cur_q <= next_addr;
               idx_q <= '0;
               st_q  <= ST_RD_REQ;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = cur_q;
      mem_wdata_o = '0;
      unique case (st_q)
         ST_RD_REQ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = cur_q + (AW'(idx_q) << 2);
         end
         ST_WR_TSL: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = cur_q + AW'(TSL_OFF);
            mem_wdata_o = ts_q[31:0];
         end
         ST_WR_TSH: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = cur_q + AW'(TSH_OFF);
            mem_wdata_o = ts_q[63:32];
         end
         ST_WR_W0: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_wdata_o = wb_word;
         end
         default: ;
      endcase
   end

   assign cmd_valid_o = (st_q == ST_CMD1) || (st_q == ST_CMD2);
   assign cmd_addr_o  = (st_q == ST_CMD2) ? dw[3] : dw[2];
   assign cmd_len_o   = (st_q == ST_CMD2) ? len2 : len1;
   assign cmd_last_o  = (st_q == ST_CMD2) || !use2;
   assign suspended_o = (st_q == ST_SUSP);

endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
   parameter int AW    = 32,
   parameter int CNT_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ext_mode_i,
   input logic             mem_req_o,
   input logic             mem_we_o,
   input logic [AW-1:0]    mem_addr_o,
   input logic [31:0]      mem_wdata_o,
   input logic             mem_ready_i,
   input logic             cmd_valid_o,
   input logic             cmd_ready_i,
   input logic [31:0]      cmd_addr_o,
   input logic [CNT_W-1:0] cmd_len_o,
   input logic             suspended_o,
   input logic [AW-1:0]    cur_addr,
   input logic [12:0]      ctrl_q
);

   logic w0_wr;
   assign w0_wr = mem_req_o && mem_we_o && (mem_addr_o == cur_addr);

   AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      w0_wr |-> !mem_wdata_o[31]); // R6
   AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      w0_wr |-> (mem_wdata_o[30:18] == ctrl_q)); // R6
   AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      w0_wr |-> !mem_wdata_o[17]); // R6
   AST_COMPACT_ONLY_W0: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o && !ext_mode_i) |-> (mem_addr_o == cur_addr)); // R7
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o))); // R9
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_addr_o)
                                         && $stable(cmd_len_o))); // R10
   AST_CMD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> (cmd_len_o != '0)); // R10
   AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      suspended_o |-> (!mem_req_o && !cmd_valid_o)); // R1

endmodule

bind txd_engine txd_engine_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_mode_i  (ext_mode_i),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_ready_i (mem_ready_i),
   .cmd_valid_o (cmd_valid_o),
   .cmd_ready_i (cmd_ready_i),
   .cmd_addr_o  (cmd_addr_o),
   .cmd_len_o   (cmd_len_o),
   .suspended_o (suspended_o),
   .cur_addr    (cur_q),
   .ctrl_q      (ctrl_q)
);

// File: tb/sim_txd_engine.sv
`timescale 1ns/1ps
module sim_txd_engine;
   localparam int AW     = 32;
   localparam int RD_LAT = 2;
   localparam int CNT_W  = 13;
   localparam logic [31:0] BASE = 32'h100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_mode_i = 1'b0;
   logic poll_i = 1'b0;
   logic mem_req_o, mem_we_o, mem_ready_i;
   logic [AW-1:0] mem_addr_o;
   logic [31:0] mem_wdata_o, mem_rdata_i;
   logic cmd_valid_o, cmd_ready_i, cmd_last_o;
   logic [31:0] cmd_addr_o;
   logic [CNT_W-1:0] cmd_len_o;
   logic done_valid_i = 1'b0;
   logic [16:0] done_status_i = '0;
   logic [63:0] done_ts_i = '0;
   logic suspended_o;

   int n_chk = 0;
   int n_bad = 0;
   int tick = 0;

   logic [31:0] mem [0:255];
   logic [31:0] rpipe [RD_LAT];
   logic [31:0] cq_addr[$];
   logic [12:0] cq_len[$];
   logic        cq_last[$];
   logic [31:0] wq_addr[$];
   logic [31:0] wq_data[$];
   logic [31:0] rq_addr[$];

   always #2 clk = ~clk;

   txd_engine #(.AW(AW), .RD_LAT(RD_LAT), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i), .list_base_i(BASE),
      .poll_i(poll_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
      .mem_rdata_i(mem_rdata_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
      .cmd_addr_o(cmd_addr_o), .cmd_len_o(cmd_len_o), .cmd_last_o(cmd_last_o),
      .done_valid_i(done_valid_i), .done_status_i(done_status_i), .done_ts_i(done_ts_i),
      .suspended_o(suspended_o)
   );

   assign mem_ready_i = (tick % 3) != 0;
   assign cmd_ready_i = (tick % 4) != 1;
   assign mem_rdata_i = rpipe[RD_LAT-1];

   // memory with fixed read latency; garbage outside the data slot
   always @(posedge clk) begin
      tick <= tick + 1;
      if (mem_req_o && mem_ready_i && mem_we_o) begin
         mem[mem_addr_o[9:2]] <= mem_wdata_o;
         wq_addr.push_back(mem_addr_o);
         wq_data.push_back(mem_wdata_o);
      end
      if (mem_req_o && mem_ready_i && !mem_we_o) begin
         rpipe[0] <= mem[mem_addr_o[9:2]];
         rq_addr.push_back(mem_addr_o);
      end else begin
         rpipe[0] <= 32'hDEAD_BEEF;
      end
      for (int i = 1; i < RD_LAT; i++) rpipe[i] <= rpipe[i-1];
      if (cmd_valid_o && cmd_ready_i) begin
         cq_addr.push_back(cmd_addr_o);
         cq_len.push_back(cmd_len_o);
         cq_last.push_back(cmd_last_o);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad + 1);
      $finish;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_poll();
      poll_i = 1'b1;
      @(negedge clk);
      poll_i = 1'b0;
   endtask

   task automatic wait_cmds(input int n);
      int g = 0;
      while (cq_addr.size() < n && g < 3000) begin @(negedge clk); g++; end
      if (g >= 3000) chk("R3 command wait timeout", 1, 0);
   endtask

   task automatic wait_susp();
      int g = 0;
      while (!suspended_o && g < 3000) begin @(negedge clk); g++; end
      chk("R1 suspended after stop", suspended_o, 1);
   endtask

   task automatic send_done(input logic [16:0] st, input logic [63:0] ts);
      repeat (3) @(negedge clk);
      done_status_i = st;
      done_ts_i = ts;
      done_valid_i = 1'b1;
      @(negedge clk);
      done_valid_i = 1'b0;
   endtask

   task automatic run_case(input int p, input bit ext);
      bit nz1, nz2, tse, chn, eor;
      logic [31:0] w0, w1, w2, w3, nxt, wexp;
      logic [12:0] b1, b2;
      logic [16:0] st;
      logic [63:0] ts;
      logic [31:0] ea[2];
      logic [12:0] el[2];
      int ne, c0, wi, r0;
      nz1 = p[0]; nz2 = p[1]; tse = p[2]; chn = p[3]; eor = p[4];
      b1 = 13'(p * 7 + 1);
      b2 = 13'(p * 11 + 3);
      w0 = 32'h8000_0000 | (32'((p * 5 + int'(ext)) & 31) << 26) | (32'(tse) << 25)
         | (32'((p + 1) & 7) << 22) | (32'(eor) << 21) | (32'(chn) << 20)
         | (32'(p & 3) << 18) | 32'h0002_A5C3;
      w1 = 32'hA000_E000 | ({19'b0, nz2 ? b2 : 13'd0} << 16) | {19'b0, nz1 ? b1 : 13'd0};
      w2 = 32'h1000_0000 + 32'(p) * 32'h40;
      w3 = chn ? 32'h200 : 32'h2000_0000 + 32'(p) * 32'h80;
      st = 17'(p * 32'h1357 + int'(ext) * 32'h8001);
      ts = {32'h7000_0000 + 32'(p), 32'h0BAD_0000 + 32'(ext) * 256 + 32'(p)};
      ne = 0;
      if (nz1) begin ea[ne] = w2; el[ne] = b1; ne++; end
      if (nz2 && !chn) begin ea[ne] = w3; el[ne] = b2; ne++; end
      nxt = chn ? 32'h200 : (eor ? BASE : BASE + (ext ? 32'd32 : 32'd16));
      wexp = {1'b0, w0[30:18], 1'b0, (ne > 0) ? st : 17'd0};

      do_reset();
      ext_mode_i = ext;
      mem[BASE[9:2]] = w0;
      mem[BASE[9:2] + 1] = w1;
      mem[BASE[9:2] + 2] = w2;
      mem[BASE[9:2] + 3] = w3;
      if (ext) for (int k = 4; k < 8; k++) mem[BASE[9:2] + 8'(k)] = 32'h25A5_0000 + 32'(k);
      c0 = cq_addr.size(); wi = wq_addr.size(); r0 = rq_addr.size();
      pulse_poll();
      wait_cmds(c0 + ne);
      if (ne > 0) send_done(st, ts);
      wait_susp();

      chk($sformatf("R3 cmd count p=%0d e=%0d", p, ext), cq_addr.size() - c0, ne);
      for (int k = 0; k < ne && c0 + k < cq_addr.size(); k++) begin
         chk($sformatf("R3 cmd addr p=%0d k=%0d", p, k), cq_addr[c0+k], ea[k]);
         chk($sformatf("R10 cmd len p=%0d k=%0d", p, k), cq_len[c0+k], el[k]);
         chk($sformatf("R3 cmd last p=%0d k=%0d", p, k), cq_last[c0+k], (k == ne - 1));
      end
      if (ne > 0 && ext && tse) begin
         chk($sformatf("R7 write count p=%0d", p), wq_addr.size() - wi, 3);
         if (wq_addr.size() - wi == 3) begin
            chk("R7 ts low addr", wq_addr[wi], BASE + 24);
            chk("R7 ts low data", wq_data[wi], ts[31:0]);
            chk("R7 ts high addr", wq_addr[wi+1], BASE + 28);
            chk("R7 ts high data", wq_data[wi+1], ts[63:32]);
            chk("R7 word0 last addr", wq_addr[wi+2], BASE);
            chk($sformatf("R6 word0 p=%0d e=%0d", p, ext), wq_data[wi+2], wexp);
         end
      end else begin
         chk($sformatf("R8 single write p=%0d e=%0d", p, ext), wq_addr.size() - wi, 1);
         if (wq_addr.size() - wi == 1) begin
            chk("R7 word0 addr", wq_addr[wi], BASE);
            chk($sformatf("R6 word0 p=%0d e=%0d", p, ext), wq_data[wi], wexp);
         end
         if (ext) chk("R7 word6 untouched", mem[BASE[9:2] + 6], 32'h25A5_0006);
      end
      chk("R9 read count", rq_addr.size() - r0, 8);
      if (rq_addr.size() - r0 == 8) begin
         for (int k = 0; k < 4; k++)
            chk("R9 fetch addr", rq_addr[r0+k], BASE + 32'(4 * k));
         chk($sformatf("R5 R4 next addr p=%0d e=%0d", p, ext), rq_addr[r0+4], nxt);
      end
   endtask

   initial begin
      int r0, c0, w0i;
      logic [31:0] d0;
      // R2: reset state and no activity without a poll
      do_reset();
      chk("R2 reset suspended", suspended_o, 0);
      chk("R2 reset req", mem_req_o, 0);
      chk("R2 reset cmd", cmd_valid_o, 0);
      r0 = rq_addr.size();
      repeat (12) @(negedge clk);
      chk("R2 idle without poll", rq_addr.size() - r0, 0);

      // R1: descriptor still owned by software
      do_reset();
      mem[BASE[9:2]] = 32'h7FFF_FFFF;
      mem[BASE[9:2] + 1] = 32'h0000_0010;
      r0 = rq_addr.size(); c0 = cq_addr.size(); w0i = wq_addr.size();
      pulse_poll();
      wait_susp();
      chk("R1 no command", cq_addr.size() - c0, 0);
      chk("R1 no write", wq_addr.size() - w0i, 0);
      chk("R2 first fetch at base", rq_addr[r0], BASE);

      // sweep of all field combinations in both layouts
      for (int e = 0; e < 2; e++)
         for (int p = 0; p < 32; p++)
            run_case(p, e[0]);

      // R2 resume: stopped at BASE+16, software hands it over, poll
      run_case(1, 1'b0);
      r0 = rq_addr.size();
      repeat (20) @(negedge clk);
      chk("R1 quiet while suspended", rq_addr.size() - r0, 0);
      d0 = 32'h8000_0000 | (32'd1 << 21) | 32'h0000_1234;
      mem[(BASE[9:2]) + 4] = d0;
      mem[(BASE[9:2]) + 5] = 32'd5;
      mem[(BASE[9:2]) + 6] = 32'h3000_0000;
      mem[(BASE[9:2]) + 7] = 32'h0;
      c0 = cq_addr.size(); w0i = wq_addr.size();
      pulse_poll();
      wait_cmds(c0 + 1);
      send_done(17'h1ABCD, 64'h1);
      wait_susp();
      chk("R2 resume fetch addr", rq_addr[r0], BASE + 16);
      chk("R2 resume cmd addr", cq_addr[c0], 32'h3000_0000);
      chk("R2 resume cmd len", cq_len[c0], 5);
      chk("R6 resume word0", mem[(BASE[9:2]) + 4], {1'b0, d0[30:18], 1'b0, 17'h1ABCD});
      chk("R5 wrap to base", rq_addr[r0+4], BASE);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule